// File: doc/BRIEF.md
# Dual-Port-Data Two-Beat Burst SRAM

This block is a synchronous memory with one shared address bus, a dedicated input path for write data and a dedicated output path for read data. Since the two data paths never share wires, no dead cycle is needed between a write and a read. Each address names a pair of words, beat 0 and beat 1. In silicon the two beats would travel on the two halves of one clock period. Here both beats sit side by side in parallel registers on a single clock. A new request can be issued on every rising edge.

A request is an active-low enable plus a read/write select. Write data for both beats comes one edge after the write request, together with active-low masks that cover 9-bit lanes. The array is written one edge after that. A read issued while a write to the same address is still waiting to be committed gets the written lanes from that pending write. Read results leave on a valid-only stream with no ready signal. The consumer must take every word in the cycle it appears, and the memory never stalls. A separate drive flag plays the part of the read bus output enable.

Top module: `sbs_burst_sram`

## Requirements
- R1: While reset is asserted and until the first read result, `rdat_vld` and `rdat_drv` are low and `rdat_b0`/`rdat_b1` are zero.
- R2: At each rising edge the request is decoded as follows. `cmd_en_n` high means idle. `cmd_en_n` low with `cmd_rd` high means read. `cmd_en_n` low with `cmd_rd` low means write. Idle and read requests never change memory contents, whatever is on the write-data and mask inputs.
- R3: For a write accepted at edge E, `wd_b0`/`wd_b1` and their masks are sampled at edge E+1. Beat 0 data is stored as word 0 of the address and beat 1 data as word 1.
- R4: For a read accepted at edge E, after edge E+2 `rdat_vld` is high for exactly one cycle. In that cycle `rdat_b0` carries word 0 and `rdat_b1` carries word 1 of the address.
- R5: Lane k is bits 9k+8 down to 9k. Mask bit k low writes lane k of that beat. Mask bit k high leaves the stored lane unchanged. Each beat has its own mask.
- R6: A read returns the result of every write accepted before it, lane by lane. This includes a write accepted on the immediately preceding edge, whose data has not yet reached the array.
- R7: The slot after edge E+2 belongs to the request accepted at edge E. `rdat_drv` goes high in a read slot and low in an idle slot, and is unchanged in a write slot. `rdat_vld` is low in idle and write slots.
- R8: While `rdat_vld` is low, `rdat_b0` and `rdat_b1` hold the last read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all requests sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en_n | input | 1 | Active-low request enable |
| cmd_rd | input | 1 | 1 = read, 0 = write, when enabled |
| cmd_addr | input | AW | Burst address |
| wd_b0 | input | 9*LANES | Write data, beat 0 (edge after the request) |
| wd_b1 | input | 9*LANES | Write data, beat 1 (edge after the request) |
| wmask_n_b0 | input | LANES | Active-low lane write mask, beat 0 |
| wmask_n_b1 | input | LANES | Active-low lane write mask, beat 1 |
| rdat_b0 | output | 9*LANES | Read result, beat 0 |
| rdat_b1 | output | 9*LANES | Read result, beat 1 |
| rdat_vld | output | 1 | Read result valid, one cycle per read, no back-pressure |
| rdat_drv | output | 1 | Read bus drive enable |

## Verification
The bench targets a read issued on the edge right after a write to the same address. A design without a forwarding path returns stale array contents in that case. A forward that ignores the masks instead overwrites lanes the write left alone. It checks that write data and masks presented during idle and read cycles leave memory untouched, which catches a design that commits whatever arrives on the data pins. Drive-flag checks cover the slot sequences read-write-idle: a design that clears the flag on a write slot, or clears it one slot late or early, fails there. Held data across non-read slots exposes output registers that load on every cycle.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned BEATS  = 2;
  // Cycles from request edge to the edge that presents the read result.
  localparam int unsigned RD_LAT = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_cmd_stage.sv
`timescale 1ns/1ps
module sbs_cmd_stage
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en_n,
  input  logic          cmd_rd,
  input  logic [AW-1:0] cmd_addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr
);
  op_e op_nxt;

  always_comb begin
    if (cmd_en_n)    op_nxt = OP_IDLE;
    else if (cmd_rd) op_nxt = OP_RD;
    else             op_nxt = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
    end else begin
      s1_op   <= op_nxt;
      s1_addr <= cmd_addr;
    end
  end
endmodule

// File: rtl/sbs_beat_bank.sv
`timescale 1ns/1ps
module sbs_beat_bank
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic                      clk,
  input  logic                      pend_wr,
  input  logic [AW-1:0]             pend_addr,
  input  logic [LANES*LANE_W-1:0]   pend_word,
  input  logic [LANES-1:0]          pend_mask_n,
  input  logic [AW-1:0]             rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_word
);
  localparam int unsigned DEPTH = 1 << AW;

  logic hit;
  assign hit = pend_wr && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (pend_wr && !pend_mask_n[g])
        cells[pend_addr] <= pend_word[g*LANE_W +: LANE_W];
    end

    // Lanes the pending write enables come from it; others from the array.
    assign rd_word[g*LANE_W +: LANE_W] = (hit && !pend_mask_n[g])
                                         ? pend_word[g*LANE_W +: LANE_W]
                                         : cells[rd_addr];
  end
endmodule

// File: rtl/sbs_pend_stage.sv
`timescale 1ns/1ps
module sbs_pend_stage
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  op_e                                  s1_op,
  input  logic [AW-1:0]                        s1_addr,
  input  logic [BEATS-1:0][LANES*LANE_W-1:0]   wd,
  input  logic [BEATS-1:0][LANES-1:0]          wmask_n,
  input  logic [BEATS-1:0][LANES*LANE_W-1:0]   arr_word,
  output op_e                                  s2_op,
  output logic [AW-1:0]                        s2_addr,
  output logic [BEATS-1:0][LANES*LANE_W-1:0]   s2_data,
  output logic [BEATS-1:0][LANES-1:0]          s2_mask_n
);
  // One data register serves both the pending write and the fetched read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op     <= OP_IDLE;
      s2_addr   <= '0;
      s2_data   <= '0;
      s2_mask_n <= '1;
    end else begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      case (s1_op)
        OP_WR: begin
          s2_data   <= wd;
          s2_mask_n <= wmask_n;
        end
        OP_RD: begin
          s2_data   <= arr_word;
          s2_mask_n <= '1;
        end
        default: s2_mask_n <= '1;
      endcase
    end
  end
endmodule

// File: rtl/sbs_out_stage.sv
`timescale 1ns/1ps
module sbs_out_stage
  import sbs_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  op_e                                s2_op,
  input  logic [BEATS-1:0][LANES*LANE_W-1:0] s2_data,
  output logic [BEATS-1:0][LANES*LANE_W-1:0] rdat,
  output logic                               vld,
  output logic                               drv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat <= '0;
      vld  <= 1'b0;
      drv  <= 1'b0;
    end else begin
      vld <= (s2_op == OP_RD);
      case (s2_op)
        OP_RD: begin
          rdat <= s2_data;
          drv  <= 1'b1;
        end
        OP_IDLE: drv <= 1'b0;
        default: drv <= drv;
      endcase
    end
  end
endmodule

// File: rtl/sbs_burst_sram.sv
`timescale 1ns/1ps
module sbs_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_en_n,
  input  logic                      cmd_rd,
  input  logic [AW-1:0]             cmd_addr,
  input  logic [LANES*LANE_W-1:0]   wd_b0,
  input  logic [LANES*LANE_W-1:0]   wd_b1,
  input  logic [LANES-1:0]          wmask_n_b0,
  input  logic [LANES-1:0]          wmask_n_b1,
  output logic [LANES*LANE_W-1:0]   rdat_b0,
  output logic [LANES*LANE_W-1:0]   rdat_b1,
  output logic                      rdat_vld,
  output logic                      rdat_drv
);
  localparam int unsigned W = LANES * LANE_W;

  op_e                         s1_op, s2_op;
  logic [AW-1:0]               s1_addr, s2_addr;
  logic [BEATS-1:0][W-1:0]     wd_arr, arr_word, s2_data, rdat;
  logic [BEATS-1:0][LANES-1:0] wmask_arr, s2_mask_n;
  logic                        pend_wr;

  assign wd_arr    = {wd_b1, wd_b0};
  assign wmask_arr = {wmask_n_b1, wmask_n_b0};
  assign pend_wr   = (s2_op == OP_WR);

  sbs_cmd_stage #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_en_n(cmd_en_n), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .s1_op(s1_op), .s1_addr(s1_addr)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    sbs_beat_bank #(.AW(AW), .LANES(LANES)) u_bank (
      .clk(clk), .pend_wr(pend_wr), .pend_addr(s2_addr),
      .pend_word(s2_data[b]), .pend_mask_n(s2_mask_n[b]),
      .rd_addr(s1_addr), .rd_word(arr_word[b])
    );
  end

  sbs_pend_stage #(.AW(AW), .LANES(LANES)) u_pend (
    .clk(clk), .rst_n(rst_n), .s1_op(s1_op), .s1_addr(s1_addr),
    .wd(wd_arr), .wmask_n(wmask_arr), .arr_word(arr_word),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_data(s2_data), .s2_mask_n(s2_mask_n)
  );

  sbs_out_stage #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .s2_op(s2_op), .s2_data(s2_data),
    .rdat(rdat), .vld(rdat_vld), .drv(rdat_drv)
  );

  assign rdat_b0 = rdat[0];
  assign rdat_b1 = rdat[1];
endmodule

// File: rtl/sbs_burst_sram_chk.sv
`timescale 1ns/1ps
module sbs_burst_sram_chk
  import sbs_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_en_n,
  input logic                    cmd_rd,
  input logic [LANES*LANE_W-1:0] rdat_b0,
  input logic [LANES*LANE_W-1:0] rdat_b1,
  input logic                    rdat_vld,
  input logic                    rdat_drv
);
  localparam logic [1:0] SLOT = 2'(RD_LAT + 1);

  // Edges seen since reset release, saturating at the slot distance.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != SLOT) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rdat_vld && !rdat_drv));

  a_r4_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == SLOT && $past(!cmd_en_n && cmd_rd, RD_LAT + 1))
      |-> (rdat_vld && rdat_drv));

  a_r7_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == SLOT && $past(cmd_en_n, RD_LAT + 1))
      |-> (!rdat_vld && !rdat_drv));

  a_r7_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == SLOT && $past(!cmd_en_n && !cmd_rd, RD_LAT + 1))
      |-> (!rdat_vld && rdat_drv == $past(rdat_drv)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !rdat_vld) |-> ($stable(rdat_b0) && $stable(rdat_b1)));
endmodule

bind sbs_burst_sram sbs_burst_sram_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en_n(cmd_en_n), .cmd_rd(cmd_rd),
  .rdat_b0(rdat_b0), .rdat_b1(rdat_b1), .rdat_vld(rdat_vld), .rdat_drv(rdat_drv)
);

// File: tb/tb_sbs_burst_sram.sv
`timescale 1ns/1ps
module tb_sbs_burst_sram;
  localparam int AW = 8;
  localparam int W  = 18;
  localparam int QN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_en_n = 1'b1, cmd_rd = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0] wd_b0 = '0, wd_b1 = '0;
  logic [1:0] wmask_n_b0 = 2'b11, wmask_n_b1 = 2'b11;
  logic [W-1:0] rdat_b0, rdat_b1;
  logic rdat_vld, rdat_drv;

  always #2 clk = ~clk;

  sbs_burst_sram #(.AW(AW), .LANES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_en_n(cmd_en_n), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .wd_b0(wd_b0), .wd_b1(wd_b1),
    .wmask_n_b0(wmask_n_b0), .wmask_n_b1(wmask_n_b1),
    .rdat_b0(rdat_b0), .rdat_b1(rdat_b1), .rdat_vld(rdat_vld), .rdat_drv(rdat_drv)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model state.
  logic [W-1:0] ref0 [256];
  logic [W-1:0] ref1 [256];
  logic m_drv = 1'b0;
  logic [W-1:0] m_last0 = '0, m_last1 = '0;

  // Request queue: op 0 idle, 1 read, 2 write.
  int q_n = 0;
  int q_op [QN];
  logic [AW-1:0] q_addr [QN];
  logic [W-1:0] q_d0 [QN], q_d1 [QN];
  logic [1:0] q_m0 [QN], q_m1 [QN];
  logic e_vld [QN], e_drv [QN];
  logic [W-1:0] e_d0 [QN], e_d1 [QN];

  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [1:0] m);
    logic [W-1:0] r = old;
    for (int l = 0; l < 2; l++) if (!m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic add(input int op, input logic [AW-1:0] a, input logic [W-1:0] d0,
                     input logic [W-1:0] d1, input logic [1:0] m0, input logic [1:0] m1);
    q_op[q_n] = op; q_addr[q_n] = a; q_d0[q_n] = d0; q_d1[q_n] = d1;
    q_m0[q_n] = m0; q_m1[q_n] = m1;
    if (op == 2) begin
      ref0[a] = merge(ref0[a], d0, m0);
      ref1[a] = merge(ref1[a], d1, m1);
    end else if (op == 1) begin
      m_last0 = ref0[a]; m_last1 = ref1[a]; m_drv = 1'b1;
    end else begin
      m_drv = 1'b0;
    end
    e_vld[q_n] = (op == 1);
    e_drv[q_n] = m_drv;
    e_d0[q_n] = m_last0; e_d1[q_n] = m_last1;
    q_n++;
  endtask

  // Drives the queue one request per cycle, checks each slot after RD_LAT edges.
  task automatic run(input string tag);
    for (int c = 0; c < q_n + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        int k = c - 3;
        string dt = e_vld[k] ? tag : "R8";
        chk(rdat_vld == e_vld[k], "R4", "rdat_vld", W'(rdat_vld), W'(e_vld[k]));
        chk(rdat_drv == e_drv[k], "R7", "rdat_drv", W'(rdat_drv), W'(e_drv[k]));
        chk(rdat_b0 == e_d0[k], dt, "rdat_b0", rdat_b0, e_d0[k]);
        chk(rdat_b1 == e_d1[k], dt, "rdat_b1", rdat_b1, e_d1[k]);
      end
      if (c < q_n) begin
        cmd_en_n = (q_op[c] == 0);
        cmd_rd   = (q_op[c] == 1);
        cmd_addr = q_addr[c];
      end else begin
        cmd_en_n = 1'b1; cmd_rd = 1'b1; cmd_addr = '0;
      end
      if (c >= 1 && c - 1 < q_n && q_op[c-1] == 2) begin
        wd_b0 = q_d0[c-1]; wd_b1 = q_d1[c-1];
        wmask_n_b0 = q_m0[c-1]; wmask_n_b1 = q_m1[c-1];
      end else begin
        // Junk with lanes enabled: must not reach memory (R2).
        wd_b0 = 18'h2AAAA ^ W'(c); wd_b1 = 18'h15555 ^ W'(c);
        wmask_n_b0 = 2'b00; wmask_n_b1 = 2'b00;
      end
    end
    q_n = 0;
    m_drv = 1'b0; // trailing idle slots have passed
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!rdat_vld, "R1", "rdat_vld", W'(rdat_vld), '0);
    chk(!rdat_drv, "R1", "rdat_drv", W'(rdat_drv), '0);
    chk(rdat_b0 == '0 && rdat_b1 == '0, "R1", "rdat_b0", rdat_b0, '0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 12; i++) add(2, AW'(i), W'(18'h01000 + i), W'(18'h20100 + i), 2'b00, 2'b00);
    add(0, 8'd3, '0, '0, 2'b00, 2'b00);
    add(1, 8'd0, '0, '0, 2'b00, 2'b00);
    add(1, 8'd3, '0, '0, 2'b00, 2'b00);
    add(0, 8'd5, '0, '0, 2'b00, 2'b00);
    add(1, 8'd5, '0, '0, 2'b00, 2'b00);
    add(1, 8'd11, '0, '0, 2'b00, 2'b00);
    run("R3");
  endtask

  task automatic t_mask;
    add(2, 8'd20, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
    add(0, 8'd0, '0, '0, 2'b11, 2'b11);
    add(2, 8'd20, 18'h00000, 18'h00000, 2'b10, 2'b01);
    add(0, 8'd0, '0, '0, 2'b11, 2'b11);
    add(0, 8'd0, '0, '0, 2'b11, 2'b11);
    add(1, 8'd20, '0, '0, 2'b11, 2'b11);
    add(2, 8'd20, 18'h12345, 18'h0ABCD, 2'b11, 2'b11);
    add(0, 8'd0, '0, '0, 2'b11, 2'b11);
    add(0, 8'd0, '0, '0, 2'b11, 2'b11);
    add(1, 8'd20, '0, '0, 2'b11, 2'b11);
    run("R5");
  endtask

  task automatic t_fwd;
    add(2, 8'd31, 18'h11111, 18'h22222, 2'b00, 2'b00);
    add(2, 8'd30, 18'h0F0F0, 18'h30303, 2'b00, 2'b00);
    add(1, 8'd30, '0, '0, 2'b00, 2'b00);
    add(2, 8'd30, 18'h3C3C3, 18'h01F1F, 2'b01, 2'b10);
    add(1, 8'd30, '0, '0, 2'b00, 2'b00);
    add(2, 8'd30, 18'h00001, 18'h00002, 2'b00, 2'b00);
    add(2, 8'd30, 18'h00A0A, 18'h00B0B, 2'b10, 2'b00);
    add(1, 8'd30, '0, '0, 2'b00, 2'b00);
    add(2, 8'd32, 18'h3ABCD, 18'h3DCBA, 2'b00, 2'b00);
    add(1, 8'd31, '0, '0, 2'b00, 2'b00);
    run("R6");
  endtask

  task automatic t_oe;
    add(1, 8'd1, '0, '0, 2'b00, 2'b00);
    add(2, 8'd40, 18'h00440, 18'h00441, 2'b00, 2'b00);
    add(2, 8'd41, 18'h00450, 18'h00451, 2'b00, 2'b00);
    add(1, 8'd2, '0, '0, 2'b00, 2'b00);
    add(0, 8'd0, '0, '0, 2'b00, 2'b00);
    add(2, 8'd42, 18'h00460, 18'h00461, 2'b00, 2'b00);
    add(1, 8'd40, '0, '0, 2'b00, 2'b00);
    add(0, 8'd0, '0, '0, 2'b00, 2'b00);
    add(0, 8'd0, '0, '0, 2'b00, 2'b00);
    add(2, 8'd43, 18'h00470, 18'h00471, 2'b00, 2'b00);
    run("R7");
  endtask

  task automatic t_rand;
    for (int i = 0; i < 60; i++) begin
      int sel;
      logic [W-1:0] d0, d1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[2:0]) % 5;
      d0 = {lfsr[1:0], lfsr};
      d1 = {lfsr[15:14], ~lfsr};
      add(sel == 0 ? 0 : (sel <= 2 ? 1 : 2), AW'(lfsr[9:8]), d0, d1, lfsr[5:4], lfsr[7:6]);
    end
    run("R2");
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin ref0[a] = '0; ref1[a] = '0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_mask;
    t_fwd;
    t_oe;
    t_rand;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule